// File: doc/BRIEF.md
# Lockable Redundantly Encoded Control Register with Repeat Detector

This block is a register slice for the front end of an entropy distribution path. It holds one control word made of four 4-bit enable fields. Each field uses a redundant code, so a single flipped bit cannot turn a setting on. A lock bit guards the control word. The lock starts set, and software can only clear it. Once it is cleared, the control word is frozen until the next reset. The rest of the design reads each field through a decoded single-bit output.

The slice also raises alarms. It flags any field that holds a value outside the two legal codes. It also watches the internal 128-bit entropy data bus, and flags a valid word that repeats the previous valid word. Each alarm sets its own sticky status bit, which software clears by writing zero. When a status bit goes from 0 to 1, the slice pulses the recoverable alert output for one cycle.

Access uses a simple word-addressed port:
- Writes are single-cycle strobes.
- Reads are combinational.
- The lock bit is at address 0, the control word at address 1 and the status word at address 2.

Top module: `mbctl_lock_reg`

## Requirements
- R1: The lock bit reads as bit 0 at address 0 and resets to 1. A write to address 0 with data bit 0 equal to 0 clears it. A later write with data bit 0 equal to 1 leaves it at 0 until reset.
- R2: The control word is at address 1. Bits 3:0 hold the module enable, bits 7:4 boot request mode, bits 11:8 auto request mode and bits 15:12 command FIFO clear. Each field resets to the false code 4'b1001. Bits 31:16 always read 0. A write to address 1 while the lock bit is 0 leaves the word unchanged.
- R3: Each decoded output (`en_module_o`, `boot_mode_o`, `auto_mode_o`, `fifo_clr_o`) is 1 only while its field holds the true code 4'b0110. It is 0 for the false code and for every illegal value. It follows the field in the cycle right after the write edge.
- R4: A field holding any value other than 4'b0110 or 4'b1001 sets its status bit one clock edge later. The bits are 0 for enable, 1 for boot mode, 2 for auto mode and 3 for FIFO clear. Status bits 11:4 always read 0.
- R5: Status bit 12 is set at the clock edge where `bus_valid_i` is high and `bus_data_i` equals the most recent earlier valid word. Cycles where `bus_valid_i` is low do not change the stored word. The first valid word after reset is never flagged, even if it is zero.
- R6: The status word is at address 2. A write there clears each status bit whose data bit is 0 and leaves the bits written 1 unchanged. If a set condition is present in the same cycle as a clear, the set wins.
- R7: `recov_alert_o` is high for exactly one cycle, in the first cycle a status bit reads 1 after being 0. It stays low while the status bits only hold or clear.
- R8: A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr_i | input | 2 | Word address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| bus_valid_i | input | 1 | Entropy bus word valid |
| bus_data_i | input | 128 | Entropy bus word |
| en_module_o | output | 1 | Decoded module enable |
| boot_mode_o | output | 1 | Decoded boot request mode |
| auto_mode_o | output | 1 | Decoded auto request mode |
| fifo_clr_o | output | 1 | Decoded command FIFO clear |
| recov_alert_o | output | 1 | One-cycle recoverable alert pulse |

## Verification
The assertions check on every cycle the rules that hold regardless of data:
- the lock never sets again once cleared;
- the control word is stable while the lock is clear;
- a pending set condition always shows up in the status word;
- status bits not written 0 are kept;
- the alert equals the 0-to-1 change of the status word;
- the repeat detector never flags before its first valid word.

Only the bench scenarios show the concrete values. They cover:
- the exact legal and illegal split over all sixteen codes in every field;
- the decoded output level for each code;
- the register map and its zero-filled bits;
- the effect of idle bus cycles between equal words.

// File: rtl/mbctl_pkg.sv
package mbctl_pkg;

  parameter int unsigned REG_W      = 32;
  parameter int unsigned ADDR_W     = 2;
  parameter int unsigned FIELD_W    = 4;
  parameter int unsigned NUM_FIELDS = 4;
  parameter int unsigned CTRL_W     = FIELD_W * NUM_FIELDS;
  parameter int unsigned REPEAT_BIT = 12;
  parameter int unsigned STS_W      = REPEAT_BIT + 1;

  parameter logic [FIELD_W-1:0] MB_TRUE  = 4'b0110;
  parameter logic [FIELD_W-1:0] MB_FALSE = 4'b1001;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LOCK = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_STS  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/mbctl_ctrl_word.sv
module mbctl_ctrl_word
  import mbctl_pkg::*;
#(
  parameter int unsigned NFLD = NUM_FIELDS,
  parameter int unsigned FW   = FIELD_W,
  localparam int unsigned CW  = NFLD * FW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lock_we_i,
  input  logic            lock_wbit_i,
  input  logic            ctrl_we_i,
  input  logic [CW-1:0]   ctrl_wdata_i,
  output logic            lock_o,
  output logic [CW-1:0]   ctrl_o,
  output logic [NFLD-1:0] field_true_o,
  output logic [NFLD-1:0] field_bad_o
);

  logic          lock_q, lock_d, lock_en;
  logic [CW-1:0] ctrl_q, ctrl_d;
  logic          ctrl_en;

  // Next-state logic: the lock can only move toward zero.
  always_comb begin
    lock_en = lock_we_i;
    lock_d  = lock_q & lock_wbit_i;
    ctrl_en = ctrl_we_i & lock_q;
    ctrl_d  = ctrl_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= {NFLD{MB_FALSE}};
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_field
    logic [FW-1:0] fld;
    logic          is_true, is_false;
    assign fld             = ctrl_q[g*FW +: FW];
    assign is_true         = (fld == MB_TRUE);
    assign is_false        = (fld == MB_FALSE);
    assign field_true_o[g] = is_true;
    assign field_bad_o[g]  = ~(is_true | is_false);
  end

  assign lock_o = lock_q;
  assign ctrl_o = ctrl_q;

  // R1: once cleared, the lock stays cleared
  p_lock_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q);

  // R2: a cleared lock freezes the control word
  p_locked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> $stable(ctrl_q));

endmodule

// File: rtl/mbctl_repeat_det.sv
module mbctl_repeat_det #(
  parameter int unsigned BUS_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             hit_o
);

  logic [BUS_W-1:0] prev_q;
  logic             seen_q, seen_d;
  logic             upd_en;

  always_comb begin
    upd_en = valid_i;
    seen_d = 1'b1;
    hit_o  = valid_i & seen_q & (data_i == prev_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (upd_en) begin
      prev_q <= data_i;
      seen_q <= seen_d;
    end
  end

  // R5: nothing is flagged before the first valid word is stored
  p_first_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !hit_o);

  // R5: a hit requires a valid word on the bus
  p_hit_needs_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_i);

endmodule

// File: rtl/mbctl_sticky_sts.sv
module mbctl_sticky_sts #(
  parameter int unsigned SW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] set_i,
  input  logic          clr_we_i,
  input  logic [SW-1:0] clr_wdata_i,
  output logic [SW-1:0] sts_o,
  output logic          alert_o
);

  logic [SW-1:0] sts_q, sts_d, clr_mask, keep;
  logic          alert_q, alert_d;

  always_comb begin
    clr_mask = clr_we_i ? ~clr_wdata_i : '0;
    keep     = sts_q & ~clr_mask;
    sts_d    = keep | set_i;
    alert_d  = |(sts_d & ~sts_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= '0;
      alert_q <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      alert_q <= alert_d;
    end
  end

  assign sts_o   = sts_q;
  assign alert_o = alert_q;

  // R4: a present set condition always lands in the status word
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(set_i)) == $past(set_i)));

  // R6: bits not written zero are retained
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(keep)) == $past(keep)));

  // R7: the alert is exactly the rising edge of the status word
  p_alert_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_q == (|(sts_q & ~$past(sts_q))));

endmodule

// File: rtl/mbctl_lock_reg.sv
module mbctl_lock_reg
  import mbctl_pkg::*;
#(
  parameter int unsigned BUS_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              bus_valid_i,
  input  logic [BUS_W-1:0]  bus_data_i,
  output logic              en_module_o,
  output logic              boot_mode_o,
  output logic              auto_mode_o,
  output logic              fifo_clr_o,
  output logic              recov_alert_o
);

  reg_addr_e             addr;
  logic                  lock_we, ctrl_we, sts_we;
  logic                  lock;
  logic [CTRL_W-1:0]     ctrl;
  logic [NUM_FIELDS-1:0] fld_true, fld_bad;
  logic                  rep_hit;
  logic [STS_W-1:0]      sts_set, sts;
  logic [REG_W-1:0]      unused_wdata;

  assign addr         = reg_addr_e'(reg_addr_i);
  assign lock_we      = reg_we_i & (addr == ADDR_LOCK);
  assign ctrl_we      = reg_we_i & (addr == ADDR_CTRL);
  assign sts_we       = reg_we_i & (addr == ADDR_STS);
  assign unused_wdata = reg_wdata_i;

  mbctl_ctrl_word #(
    .NFLD(NUM_FIELDS),
    .FW  (FIELD_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_we_i   (lock_we),
    .lock_wbit_i (reg_wdata_i[0]),
    .ctrl_we_i   (ctrl_we),
    .ctrl_wdata_i(reg_wdata_i[CTRL_W-1:0]),
    .lock_o      (lock),
    .ctrl_o      (ctrl),
    .field_true_o(fld_true),
    .field_bad_o (fld_bad)
  );

  mbctl_repeat_det #(
    .BUS_W(BUS_W)
  ) u_rep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(bus_valid_i),
    .data_i (bus_data_i),
    .hit_o  (rep_hit)
  );

  always_comb begin
    sts_set                   = '0;
    sts_set[NUM_FIELDS-1:0]   = fld_bad;
    sts_set[REPEAT_BIT]       = rep_hit;
  end

  mbctl_sticky_sts #(
    .SW(STS_W)
  ) u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (sts_set),
    .clr_we_i   (sts_we),
    .clr_wdata_i(reg_wdata_i[STS_W-1:0]),
    .sts_o      (sts),
    .alert_o    (recov_alert_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      ADDR_LOCK: reg_rdata_o[0]          = lock;
      ADDR_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl;
      ADDR_STS:  reg_rdata_o[STS_W-1:0]  = sts;
      default:   reg_rdata_o             = '0;
    endcase
  end

  assign en_module_o = fld_true[0];
  assign boot_mode_o = fld_true[1];
  assign auto_mode_o = fld_true[2];
  assign fifo_clr_o  = fld_true[3];

  // R3: no two decoded outputs disagree with a single legal field each
  p_out_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_module_o |-> (reg_addr_i != ADDR_CTRL) || (reg_rdata_o[3:0] == MB_TRUE));

  // R4: status bits 11:4 never set
  p_gap_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts[REPEAT_BIT-1:NUM_FIELDS] == '0);

endmodule

// File: tb/mbctl_lock_reg_tb.sv
module mbctl_lock_reg_tb;

  logic         clk, rst_n;
  logic         we;
  logic [1:0]   addr;
  logic [31:0]  wdata, rdata;
  logic         bvalid;
  logic [127:0] bdata;
  logic         en_o, boot_o, auto_o, clr_o, alert;

  int vectors = 0;
  int fails   = 0;
  int alert_cnt = 0;
  bit done = 0;

  mbctl_lock_reg u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_we_i     (we),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .bus_valid_i  (bvalid),
    .bus_data_i   (bdata),
    .en_module_o  (en_o),
    .boot_mode_o  (boot_o),
    .auto_mode_o  (auto_o),
    .fifo_clr_o   (clr_o),
    .recov_alert_o(alert)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && alert) alert_cnt++;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic bus(input logic v, input logic [127:0] d);
    @(negedge clk);
    bvalid = v; bdata = d;
    @(negedge clk);
    bvalid = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {clr_o, auto_o, boot_o, en_o};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int a0;
    we = 0; addr = 0; wdata = 0; bvalid = 0; bdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(2'd0, r); check("R1 lock reset", r, 32'h1);
    rd(2'd1, r); check("R2 ctrl reset", r, 32'h9999);
    rd(2'd2, r); check("R6 status reset", r, 32'h0);
    check("R3 outputs reset", {28'h0, outs()}, 32'h0);
    check("R7 no alert at reset", alert_cnt, 0);
    rd(2'd3, r); check("R8 addr3 reads zero", r, 32'h0);

    // Sweep every code in every field
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 16; v++) begin
        logic [15:0] word;
        bit bad;
        word = 16'h9999;
        word[f*4 +: 4] = 4'(v);
        bad = (v != 6) && (v != 9);
        a0 = alert_cnt;
        wr(2'd1, {16'h0, word});
        check("R3 decoded output", {28'h0, outs()}, (v == 6) ? (32'h1 << f) : 32'h0);
        @(negedge clk); @(negedge clk);
        rd(2'd2, r);
        check("R4 illegal code status", r, bad ? (32'h1 << f) : 32'h0);
        check("R7 alert per new status bit", alert_cnt - a0, bad ? 1 : 0);
        rd(2'd1, r);
        check("R2 ctrl readback", r, {16'h0, word});
        wr(2'd1, 32'h9999);
        wr(2'd2, 32'h0);
        rd(2'd2, r);
        check("R6 clear by zero", r, 32'h0);
      end
    end

    // Upper bits ignored, all fields true
    wr(2'd1, 32'hFFFF_6666);
    rd(2'd1, r); check("R2 upper bits read zero", r, 32'h6666);
    check("R3 all outputs true", {28'h0, outs()}, 32'hF);

    // Set wins over clear, write-one has no effect
    a0 = alert_cnt;
    wr(2'd1, 32'h0000_6660);
    @(negedge clk);
    rd(2'd2, r); check("R4 enable field illegal", r, 32'h1);
    wr(2'd2, 32'h0);
    rd(2'd2, r); check("R6 set wins over clear", r, 32'h1);
    wr(2'd1, 32'h9999);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, r); check("R6 write one keeps bit", r, 32'h1);
    check("R7 single pulse for held bit", alert_cnt - a0, 1);
    wr(2'd2, 32'h0);
    rd(2'd2, r); check("R6 cleared", r, 32'h0);

    // Bus repeat detector
    a0 = alert_cnt;
    bus(1'b1, 128'h0);
    rd(2'd2, r); check("R5 first word never flagged", r, 32'h0);
    bus(1'b0, 128'h0);
    rd(2'd2, r); check("R5 invalid cycle ignored", r, 32'h0);
    bus(1'b1, {4{32'hA5A5_0001}});
    bus(1'b0, {4{32'h1234_5678}});
    bus(1'b1, {4{32'hA5A5_0002}});
    rd(2'd2, r); check("R5 distinct words not flagged", r, 32'h0);
    bus(1'b0, {4{32'hA5A5_0003}});
    bus(1'b1, {4{32'hA5A5_0002}});
    rd(2'd2, r); check("R5 repeat across idle flagged", r, 32'h1000);
    @(negedge clk);
    check("R7 alert on repeat", alert_cnt - a0, 1);
    wr(2'd2, 32'h0);
    bus(1'b1, {4{32'hA5A5_0004}});
    rd(2'd2, r); check("R5 new word after clear", r, 32'h0);
    bus(1'b1, {4{32'hA5A5_0004}});
    rd(2'd2, r); check("R5 back-to-back repeat", r, 32'h1000);
    wr(2'd2, 32'h0);

    // Lock behaviour
    wr(2'd0, 32'h1);
    rd(2'd0, r); check("R1 write one keeps lock", r, 32'h1);
    wr(2'd0, 32'h0);
    rd(2'd0, r); check("R1 write zero clears lock", r, 32'h0);
    wr(2'd0, 32'h1);
    rd(2'd0, r); check("R1 lock cannot be set again", r, 32'h0);
    wr(2'd1, 32'h6666);
    rd(2'd1, r); check("R2 locked write ignored", r, 32'h9999);
    check("R3 outputs unchanged when locked", {28'h0, outs()}, 32'h0);
    rd(2'd3, r); check("R8 addr3 still zero", r, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule